// File: doc/BRIEF.md
# Interrupt Cause Register with Set/Clear Access and Dual Delivery

This block keeps a parameterised interrupt cause register (32 bits by default). Internal event sources raise cause bits through a per-bit request vector. Software raises bits by writing to a set offset and removes them by writing to a clear offset. It reads the register back at a status offset. A write to any other offset has no effect.

The same register feeds two delivery styles, chosen by a mode input. With message mode off, the block drives a level interrupt line. A raise that leaves the register nonzero asserts the line. The line drops only when a clear leaves every cause bit at zero. With message mode on, each raise event that leaves the register nonzero produces a one-clock trigger pulse. A downstream bus agent turns that pulse into a message. A clear never produces a pulse.

All outputs are registered. A clear and a source raise in the same cycle resolve as clear first, then set, so that a fresh event is never lost.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset the cause register reads 0, `level_irq_o` is 0 and `msg_pulse_o` is 0.
- R2: With `rd_addr_i` = 0x24, `rd_data_o` shows, one clock later, the cause value held before that clock edge. Any other read address gives 0.
- R3: A write at offset 0x60 ORs `wr_data_i` into the cause register. Each high bit of `src_raise_i` sets the matching cause bit in the same way.
- R4: A write at offset 0x64 clears every cause bit that is 1 in `wr_data_i` and leaves the other bits unchanged.
- R5: When a clear write and a source raise occur in the same cycle, the result is (cause & ~clear_data) | raise_bits.
- R6: A write to any offset other than 0x60 or 0x64, including 0x24, leaves the cause register unchanged and produces no pulse.
- R7: With `msg_mode_i` = 0, a raise event that leaves the register nonzero sets `level_irq_o` at the next clock edge, and `msg_pulse_o` stays 0.
- R8: `level_irq_o` falls only on a clear write, made with `msg_mode_i` = 0, that leaves the register zero. A partial clear keeps the line high.
- R9: With `msg_mode_i` = 1, each raise event that leaves the register nonzero gives `msg_pulse_o` = 1 for exactly the following clock cycle. This includes a set write whose bits are already set.
- R10: A clear write with no raise in the same cycle never produces a pulse, in either mode.
- R11: With `msg_mode_i` = 1, `level_irq_o` holds its value: raises do not assert it and clears do not drop it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_mode_i | input | 1 | 1 selects pulse delivery, 0 selects level delivery |
| src_raise_i | input | CAUSE_W | Per-bit raise requests from internal sources |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write offset |
| wr_data_i | input | CAUSE_W | Write data |
| rd_addr_i | input | ADDR_W | Read offset |
| rd_data_o | output | CAUSE_W | Registered read data |
| level_irq_o | output | 1 | Level interrupt line |
| msg_pulse_o | output | 1 | One-cycle message trigger |

## Verification
The hardest case to reach from the ports is the line-hold rule. The level line must stay high through a full clear made while message mode is on. It must then drop on a later clear after the mode returns to legacy, even though that clear removes no bits. The bench reaches this state in five steps:
- It raises a bit in legacy mode.
- It switches to message mode.
- It clears everything.
- It switches back to legacy mode.
- It writes a clear with zero data.

A same-cycle clear and source raise is driven on one negative edge so that both land on the same clock edge.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2
  } wr_op_e;
endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import irq_cause_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          W       = 32,
  parameter logic [7:0]  SET_OFS = 8'h60,
  parameter logic [7:0]  CLR_OFS = 8'h64
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output wr_op_e            op,
  output logic [W-1:0]      set_vec,
  output logic [W-1:0]      clr_vec
);
  localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_OFS);
  localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFS);

  always_comb begin
    op      = OP_NONE;
    set_vec = '0;
    clr_vec = '0;
    if (wr_en) begin
      if (wr_addr == SET_A) begin
        op      = OP_SET;
        set_vec = wr_data;
      end else if (wr_addr == CLR_A) begin
        op      = OP_CLR;
        clr_vec = wr_data;
      end
    end
  end
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int         W          = 32,
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] STATUS_OFS = 8'h24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      set_vec,
  input  logic [W-1:0]      clr_vec,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      cause_q,
  output logic [W-1:0]      cause_d,
  output logic [W-1:0]      rd_data
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_OFS);

  // clear first, then set: a raise in the same cycle survives
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign cause_d[b] = (cause_q[b] & ~clr_vec[b]) | set_vec[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      rd_data <= '0;
    end else begin
      cause_q <= cause_d;
      rd_data <= (rd_addr == STAT_A) ? cause_q : '0;
    end
  end
endmodule

// File: rtl/irq_delivery.sv
module irq_delivery (
  input  logic clk,
  input  logic rst,
  input  logic msg_mode,
  input  logic raise_evt,
  input  logic clr_evt,
  input  logic next_nonzero,
  output logic level_o,
  output logic pulse_o
);
  logic raise_live;
  assign raise_live = raise_evt & next_nonzero;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_o <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= msg_mode & raise_live;
      if (!msg_mode) begin
        if (raise_live)
          level_o <= 1'b1;
        else if (clr_evt && !next_nonzero)
          level_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int         CAUSE_W    = 32,
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] STATUS_OFS = 8'h24,
  parameter logic [7:0] SET_OFS    = 8'h60,
  parameter logic [7:0] CLR_OFS    = 8'h64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               msg_mode_i,
  input  logic [CAUSE_W-1:0] src_raise_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [CAUSE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [CAUSE_W-1:0] rd_data_o,
  output logic               level_irq_o,
  output logic               msg_pulse_o
);
  wr_op_e             op;
  logic [CAUSE_W-1:0] sw_set, sw_clr, set_all;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               raise_evt, clr_evt;

  irq_wr_decode #(
    .ADDR_W(ADDR_W), .W(CAUSE_W), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
  ) u_dec (
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .op(op), .set_vec(sw_set), .clr_vec(sw_clr)
  );

  assign set_all   = sw_set | src_raise_i;
  assign raise_evt = (op == OP_SET) | (|src_raise_i);
  assign clr_evt   = (op == OP_CLR);

  irq_cause_reg #(
    .W(CAUSE_W), .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS)
  ) u_reg (
    .clk(clk), .rst(rst), .set_vec(set_all), .clr_vec(sw_clr),
    .rd_addr(rd_addr_i), .cause_q(cause_q), .cause_d(cause_d),
    .rd_data(rd_data_o)
  );

  irq_delivery u_dlv (
    .clk(clk), .rst(rst), .msg_mode(msg_mode_i),
    .raise_evt(raise_evt), .clr_evt(clr_evt),
    .next_nonzero(|cause_d),
    .level_o(level_irq_o), .pulse_o(msg_pulse_o)
  );
endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk #(
  parameter int         W       = 32,
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] CLR_OFS = 8'h64
) (
  input logic              clk,
  input logic              rst,
  input logic              msg_mode_i,
  input logic [W-1:0]      src_raise_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              level_irq_o,
  input logic              msg_pulse_o,
  input logic [W-1:0]      cause_q
);
  localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFS);
  logic clr_wr;
  assign clr_wr = wr_en_i && (wr_addr_i == CLR_A);

  // R3
  src_bits_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|src_raise_i) |=> ((cause_q & $past(src_raise_i)) == $past(src_raise_i)));

  // R7
  legacy_raise_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!msg_mode_i && (|src_raise_i)) |=> (level_irq_o && !msg_pulse_o));

  // R8
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (level_irq_o && !clr_wr) |=> level_irq_o);

  // R9
  pulse_mode_only_chk: assert property (@(posedge clk) disable iff (rst)
    !msg_mode_i |=> !msg_pulse_o);

  // R10
  clear_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && (src_raise_i == '0)) |=> !msg_pulse_o);

  // R11
  msg_level_stable_chk: assert property (@(posedge clk) disable iff (rst)
    msg_mode_i |=> $stable(level_irq_o));
endmodule

bind irq_cause_ctrl irq_cause_chk #(
  .W(CAUSE_W), .ADDR_W(ADDR_W), .CLR_OFS(CLR_OFS)
) u_chk (
  .clk(clk), .rst(rst), .msg_mode_i(msg_mode_i), .src_raise_i(src_raise_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .level_irq_o(level_irq_o),
  .msg_pulse_o(msg_pulse_o), .cause_q(cause_q)
);

// File: tb/sim_irq_cause_ctrl.sv
`timescale 1ns/1ps
module sim_irq_cause_ctrl;
  localparam int W = 32;
  localparam int AW = 8;
  localparam logic [7:0] A_STAT = 8'h24, A_SET = 8'h60, A_CLR = 8'h64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          msg_mode_i = 1'b0;
  logic [W-1:0]  src_raise_i = '0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [W-1:0]  wr_data_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [W-1:0]  rd_data_o;
  logic          level_irq_o, msg_pulse_o;

  int n_chk = 0, n_bad = 0;
  logic last_pulse;
  logic [W-1:0] rv;

  always #5 clk = ~clk;

  irq_cause_ctrl u0 (
    .clk(clk), .rst(rst), .msg_mode_i(msg_mode_i), .src_raise_i(src_raise_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .level_irq_o(level_irq_o), .msg_pulse_o(msg_pulse_o)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk); #1;
    last_pulse = msg_pulse_o;
    wr_en_i = 1'b0;
  endtask

  task automatic raise(input logic [W-1:0] v);
    @(negedge clk);
    src_raise_i = v;
    @(posedge clk); #1;
    last_pulse = msg_pulse_o;
    src_raise_i = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] v);
    @(negedge clk);
    rd_addr_i = a;
    @(posedge clk); #1;
    v = rd_data_o;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; msg_mode_i = 1'b0;
    @(posedge clk); #1; @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    rd(A_STAT, rv);
    chk("R1 cause", rv, 0);
    chk("R1 level", {31'b0, level_irq_o}, 0);
    chk("R1 pulse", {31'b0, msg_pulse_o}, 0);
  endtask

  task automatic t_set_and_read();
    do_reset();
    wr(A_SET, 32'h0000_00A0);
    rd(A_STAT, rv);
    chk("R3 set write", rv, 32'h0000_00A0);
    raise(32'h0001_0000);
    rd(A_STAT, rv);
    chk("R3 source raise", rv, 32'h0001_00A0);
    rd(8'h20, rv);
    chk("R2 other read addr", rv, 0);
  endtask

  task automatic t_clear();
    wr(A_CLR, 32'h0000_0020);
    rd(A_STAT, rv);
    chk("R4 partial clear", rv, 32'h0001_0080);
  endtask

  task automatic t_same_cycle();
    do_reset();
    wr(A_SET, 32'h0000_000F);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = A_CLR; wr_data_i = 32'h3; src_raise_i = 32'h1;
    @(posedge clk); #1;
    wr_en_i = 1'b0; src_raise_i = '0;
    rd(A_STAT, rv);
    chk("R5 clear then set", rv, 32'h0000_000D);
  endtask

  task automatic t_ignored();
    do_reset();
    msg_mode_i = 1'b1;
    wr(A_SET, 32'h1);
    wr(A_STAT, 32'hFFFF_FFFF);
    chk("R6 no pulse on status write", {31'b0, last_pulse}, 0);
    wr(8'h68, 32'hFFFF_FFFF);
    rd(A_STAT, rv);
    chk("R6 cause unchanged", rv, 32'h1);
    msg_mode_i = 1'b0;
  endtask

  task automatic t_legacy();
    do_reset();
    raise(32'h4);
    chk("R7 level set", {31'b0, level_irq_o}, 1);
    chk("R7 no pulse", {31'b0, last_pulse}, 0);
    wr(A_SET, 32'h8);
    wr(A_CLR, 32'h4);
    chk("R8 partial clear keeps line", {31'b0, level_irq_o}, 1);
    chk("R10 no pulse legacy clear", {31'b0, last_pulse}, 0);
    wr(A_CLR, 32'h8);
    chk("R8 full clear drops line", {31'b0, level_irq_o}, 0);
  endtask

  task automatic t_msg();
    do_reset();
    msg_mode_i = 1'b1;
    wr(A_SET, 32'h2);
    chk("R9 pulse on set", {31'b0, last_pulse}, 1);
    idle();
    chk("R9 pulse one cycle", {31'b0, msg_pulse_o}, 0);
    wr(A_SET, 32'h2);
    chk("R9 pulse on repeat set", {31'b0, last_pulse}, 1);
    idle();
    raise(32'h10);
    chk("R9 pulse on source", {31'b0, last_pulse}, 1);
    chk("R11 no level in msg mode", {31'b0, level_irq_o}, 0);
    wr(A_CLR, 32'hFFFF_FFFF);
    chk("R10 no pulse msg clear", {31'b0, last_pulse}, 0);
    msg_mode_i = 1'b0;
  endtask

  task automatic t_hold();
    do_reset();
    raise(32'h1);
    msg_mode_i = 1'b1;
    wr(A_CLR, 32'hFFFF_FFFF);
    chk("R11 level held through msg clear", {31'b0, level_irq_o}, 1);
    msg_mode_i = 1'b0;
    idle();
    chk("R8 no drop without clear", {31'b0, level_irq_o}, 1);
    wr(A_CLR, 32'h0);
    chk("R8 legacy clear at zero drops", {31'b0, level_irq_o}, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_set_and_read();
        t_clear();
        t_same_cycle();
        t_ignored();
        t_legacy();
        t_msg();
        t_hold();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule